// File: doc/BRIEF.md
# Three-Mode Power Clock Controller

This block decides which clock domains of a small controller receive their clock. It drives three enables: one for the execution and bus domain, one for the peripheral domain, and one for the crystal oscillator. In Active mode all three are on. In Idle mode only the execution and bus clock is stopped, so timers and serial units keep running. In Powerdown mode every internal clock is stopped and the oscillator is switched off. Register contents are held in both low-power modes.

Software writes a target mode and a go bit into a control register to enter a low-power mode. An enabled interrupt brings the block from Idle back to Active on the next clock. An external wake pin ends Powerdown: the oscillator is switched on first, a programmable settle count runs out, and then the clocks are released. While the block is not plainly Active, control writes are discarded. A status register always shows the current mode.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset, cpu_clk_en, per_clk_en and osc_en are 1, status reads mode 0 with busy 0, the settle register reads 16 and the interrupt mask reads all ones.
- R2: Register map: address 0 is control, with target mode in bits [1:0] (1 = Idle, 2 = Powerdown) and go in bit 2. Go reads back as 0. Address 1 is the settle count. Address 2 is the read-only status, with mode code in [1:0] (0 Active, 1 Idle, 2 Powerdown) and busy in bit 2. Address 3 is the interrupt mask, where bit i enables irq_req[i]. Reads are combinational, and status never shows code 3.
- R3: A go write with target 1 in Active gives one busy cycle with all enables on. After that cpu_clk_en is 0, per_clk_en and osc_en stay 1, and status reads Idle with busy 0.
- R4: A go write with target 2 in Active gives one busy cycle with cpu_clk_en 0 and the other two enables at 1. After that all three enables are 0 and status reads Powerdown.
- R5: In Idle, an irq_req bit whose mask bit is 1, sampled at a rising edge, returns the block to Active at that edge. Masked interrupts and ext_wake leave Idle unchanged.
- R6: In Powerdown, ext_wake sampled at a rising edge sets osc_en at that edge while the clock enables stay 0. All enables return to 1 after S+1 further edges, where S is the settle register value. During settling, status reads Powerdown with busy 1. Interrupts have no effect in Powerdown.
- R7: A go write with target 0 or 3 causes no mode change and no busy cycle.
- R8: A control write that arrives when the block is not in Active with busy 0 is discarded: the stored target is not changed and no transition starts.
- R9: The settle and mask registers keep their values across Idle and Powerdown.
- R10: All three enables are registered outputs that change only just after a rising clock edge. osc_en is already 1 in the cycle before cpu_clk_en rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for reg_addr |
| irq_req | input | N_IRQ | Interrupt request levels |
| ext_wake | input | 1 | External wake from Powerdown |
| cpu_clk_en | output | 1 | Execution and bus clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |

## Verification
Two things can land on the same Idle edge: an interrupt wake and a control write that asks for Powerdown. The bench raises both in one cycle and expects Active with the old target still stored, because the write was rejected as it arrived outside Active. A second collision writes a new go command during the single transit cycle of Idle entry. The bench expects the block to settle in Idle and never reach Powerdown. The bench also mixes random settle counts, masks and interrupt lines, and compares the wake latency against a bench function.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE   = 3'd0,
    ST_ENT_IDLE = 3'd1,
    ST_IDLE     = 3'd2,
    ST_ENT_PD   = 3'd3,
    ST_PD       = 3'd4,
    ST_SETTLE   = 3'd5
  } pwr_state_e;

  localparam logic [1:0] MODE_ACTIVE = 2'd0;
  localparam logic [1:0] MODE_IDLE   = 2'd1;
  localparam logic [1:0] MODE_PD     = 2'd2;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_SETTLE = 2'd1;
  localparam logic [1:0] ADDR_STATUS = 2'd2;
  localparam logic [1:0] ADDR_MASK   = 2'd3;

  localparam int GO_BIT = 2;

  typedef struct packed {
    logic cpu;
    logic per;
    logic osc;
  } clk_en_t;

  // Which domains run in a given state
  function automatic clk_en_t enables_for(pwr_state_e s);
    clk_en_t e;
    unique case (s)
      ST_ACTIVE, ST_ENT_IDLE: e = '{cpu: 1'b1, per: 1'b1, osc: 1'b1};
      ST_IDLE, ST_ENT_PD:     e = '{cpu: 1'b0, per: 1'b1, osc: 1'b1};
      ST_PD:                  e = '{cpu: 1'b0, per: 1'b0, osc: 1'b0};
      ST_SETTLE:              e = '{cpu: 1'b0, per: 1'b0, osc: 1'b1};
      default:                e = '{cpu: 1'b1, per: 1'b1, osc: 1'b1};
    endcase
    return e;
  endfunction

  // Mode code reported in status
  function automatic logic [1:0] mode_code(pwr_state_e s);
    unique case (s)
      ST_IDLE:          return MODE_IDLE;
      ST_PD, ST_SETTLE: return MODE_PD;
      default:          return MODE_ACTIVE;
    endcase
  endfunction

  function automatic logic is_busy(pwr_state_e s);
    return (s == ST_ENT_IDLE) || (s == ST_ENT_PD) || (s == ST_SETTLE);
  endfunction

  // Edges from a sampled wake until the clocks run again
  function automatic int settle_edges(int count);
    return count + 1;
  endfunction

endpackage

// File: rtl/pwr_mode_regs.sv
module pwr_mode_regs
  import pwr_mode_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8,
  parameter int N_IRQ      = 4,
  parameter int RST_SETTLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              accept_ctrl,
  input  logic [1:0]        status_mode,
  input  logic              status_busy,
  output logic              go_pulse,
  output logic [1:0]        go_target,
  output logic [CNT_W-1:0]  settle_val,
  output logic [N_IRQ-1:0]  irq_mask
);

  logic [1:0]       ctrl_q;
  logic [CNT_W-1:0] settle_q;
  logic [N_IRQ-1:0] mask_q;
  logic             ctrl_wr;
  logic             ctrl_take;

  assign ctrl_wr   = reg_wr && (reg_addr == ADDR_CTRL);
  assign ctrl_take = ctrl_wr && accept_ctrl;
  assign go_pulse  = ctrl_take && reg_wdata[GO_BIT];
  assign go_target = reg_wdata[1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= MODE_ACTIVE;
      settle_q <= CNT_W'(RST_SETTLE);
      mask_q   <= '1;
    end else begin
      if (ctrl_take) ctrl_q <= reg_wdata[1:0];
      if (reg_wr && reg_addr == ADDR_SETTLE) settle_q <= reg_wdata[CNT_W-1:0];
      if (reg_wr && reg_addr == ADDR_MASK)   mask_q   <= reg_wdata[N_IRQ-1:0];
    end
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_CTRL:   reg_rdata = DATA_W'(ctrl_q);
      ADDR_SETTLE: reg_rdata = DATA_W'(settle_q);
      ADDR_STATUS: reg_rdata = DATA_W'({status_busy, status_mode});
      default:     reg_rdata = DATA_W'(mask_q);
    endcase
  end

  assign settle_val = settle_q;
  assign irq_mask   = mask_q;

  AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr && !accept_ctrl |=> $stable(ctrl_q)); // R8

  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    status_mode != 2'd3); // R2

endmodule

// File: rtl/pwr_settle_cnt.sv
module pwr_settle_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt_q <= '0;
    else if (load)                  cnt_q <= load_val;
    else if (run && cnt_q != '0)    cnt_q <= cnt_q - CNT_W'(1);
  end

  assign done = (cnt_q == '0);

  AST_SETTLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    run && !done && !load |=> cnt_q == $past(cnt_q) - CNT_W'(1)); // R6

  AST_SETTLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(load_val)); // R6

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_mode_pkg::*;
#(
  parameter int N_IRQ = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go_pulse,
  input  logic [1:0]       go_target,
  input  logic [N_IRQ-1:0] irq_req,
  input  logic [N_IRQ-1:0] irq_mask,
  input  logic             ext_wake,
  input  logic             settle_done,
  output logic             load_settle,
  output logic             settle_run,
  output logic             accept_ctrl,
  output logic [1:0]       status_mode,
  output logic             status_busy,
  output clk_en_t          en
);

  pwr_state_e state_q, state_d;
  clk_en_t    en_q;
  logic       irq_hit;
  logic       pd_wake;

  assign irq_hit = |(irq_req & irq_mask);
  assign pd_wake = (state_q == ST_PD) && ext_wake;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_ACTIVE: begin
        if (go_pulse && go_target == MODE_IDLE)    state_d = ST_ENT_IDLE;
        else if (go_pulse && go_target == MODE_PD) state_d = ST_ENT_PD;
      end
      ST_ENT_IDLE: state_d = ST_IDLE;
      ST_IDLE:     if (irq_hit) state_d = ST_ACTIVE;
      ST_ENT_PD:   state_d = ST_PD;
      ST_PD:       if (ext_wake) state_d = ST_SETTLE;
      ST_SETTLE:   if (settle_done) state_d = ST_ACTIVE;
      default:     state_d = ST_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_ACTIVE;
      en_q    <= '{cpu: 1'b1, per: 1'b1, osc: 1'b1};
    end else begin
      state_q <= state_d;
      en_q    <= enables_for(state_d);
    end
  end

  assign load_settle = pd_wake;
  assign settle_run  = (state_q == ST_SETTLE);
  assign accept_ctrl = (state_q == ST_ACTIVE);
  assign status_mode = mode_code(state_q);
  assign status_busy = is_busy(state_q);
  assign en          = en_q;

  AST_IDLE_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IDLE && irq_hit |=> en_q.cpu && en_q.per); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_IDLE && !irq_hit |=> !en_q.cpu && en_q.per && en_q.osc); // R5

  AST_IDLE_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    go_pulse && state_q == ST_ACTIVE && go_target == MODE_IDLE
      |=> ##1 (!en_q.cpu && en_q.per && en_q.osc)); // R3

  AST_PD_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    go_pulse && state_q == ST_ACTIVE && go_target == MODE_PD
      |=> ##1 (!en_q.cpu && !en_q.per && !en_q.osc)); // R4

  AST_OSC_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    pd_wake |=> en_q.osc && !en_q.cpu && !en_q.per); // R6

  AST_OSC_BEFORE_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q.cpu) |-> $past(en_q.osc)); // R10

  AST_NO_BAD_GO: assert property (@(posedge clk) disable iff (!rst_n)
    go_pulse && (go_target == MODE_ACTIVE || go_target == 2'd3) && state_q == ST_ACTIVE
      |=> state_q == ST_ACTIVE); // R7

endmodule

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl
  import pwr_mode_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int CNT_W      = 8,
  parameter int N_IRQ      = 4,
  parameter int RST_SETTLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic [N_IRQ-1:0]  irq_req,
  input  logic              ext_wake,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en
);

  logic             go_pulse;
  logic [1:0]       go_target;
  logic [CNT_W-1:0] settle_val;
  logic [N_IRQ-1:0] irq_mask;
  logic             accept_ctrl;
  logic [1:0]       status_mode;
  logic             status_busy;
  logic             load_settle;
  logic             settle_run;
  logic             settle_done;
  clk_en_t          en;

  pwr_mode_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .N_IRQ(N_IRQ), .RST_SETTLE(RST_SETTLE)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .accept_ctrl(accept_ctrl),
    .status_mode(status_mode), .status_busy(status_busy), .go_pulse(go_pulse),
    .go_target(go_target), .settle_val(settle_val), .irq_mask(irq_mask)
  );

  pwr_settle_cnt #(.CNT_W(CNT_W)) u_settle (
    .clk(clk), .rst_n(rst_n), .load(load_settle), .load_val(settle_val),
    .run(settle_run), .done(settle_done)
  );

  pwr_mode_fsm #(.N_IRQ(N_IRQ)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go_pulse(go_pulse), .go_target(go_target),
    .irq_req(irq_req), .irq_mask(irq_mask), .ext_wake(ext_wake),
    .settle_done(settle_done), .load_settle(load_settle), .settle_run(settle_run),
    .accept_ctrl(accept_ctrl), .status_mode(status_mode),
    .status_busy(status_busy), .en(en)
  );

  assign cpu_clk_en = en.cpu;
  assign per_clk_en = en.per;
  assign osc_en     = en.osc;

endmodule

// File: tb/pwr_mode_ctl_tb.sv
module pwr_mode_ctl_tb;

  localparam int DATA_W = 8;
  localparam int N_IRQ  = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              reg_wr = 1'b0;
  logic [1:0]        reg_addr = 2'd0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic [N_IRQ-1:0]  irq_req = '0;
  logic              ext_wake = 1'b0;
  logic              cpu_clk_en, per_clk_en, osc_en;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #4 clk = ~clk;

  pwr_mode_ctl u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .ext_wake(ext_wake), .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en),
    .osc_en(osc_en)
  );

  // Bench model: status word, enable triple, wake latency in negedges
  function automatic int status_word(int mode, int busy);
    return mode + 4 * busy;
  endfunction

  function automatic int en_word(int c, int p, int o);
    return 4 * c + 2 * p + o;
  endfunction

  function automatic int pd_wake_negedges(int s);
    return s + 2;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int en_now();
    return en_word(int'(cpu_clk_en), int'(per_clk_en), int'(osc_en));
  endfunction

  task automatic wr(logic [1:0] a, logic [DATA_W-1:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output int v);
    reg_addr = a;
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic enter_idle();
    int v;
    wr(2'd0, 8'h05);
    rd(2'd2, v); check("R3 transit status", v, status_word(0, 1));
    check("R3 transit enables", en_now(), en_word(1, 1, 1));
    @(negedge clk);
    rd(2'd2, v); check("R3 idle status", v, status_word(1, 0));
    check("R3 idle enables", en_now(), en_word(0, 1, 1));
  endtask

  task automatic enter_pd();
    int v;
    wr(2'd0, 8'h06);
    check("R4 transit enables", en_now(), en_word(0, 1, 1));
    @(negedge clk);
    rd(2'd2, v); check("R4 pd status", v, status_word(2, 0));
    check("R4 pd enables", en_now(), en_word(0, 0, 0));
  endtask

  task automatic wake_pd(int s);
    int cnt;
    int v;
    ext_wake = 1'b1;
    cnt = 0;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      cnt++;
      if (cnt == 1) begin
        ext_wake = 1'b0;
        check("R6 osc first", en_now(), (s == -1) ? 0 : en_word(0, 0, 1));
        rd(2'd2, v); check("R6 settle status", v, status_word(2, 1));
      end
      if (cpu_clk_en) break;
    end
    check("R6 wake latency", cnt, pd_wake_negedges(s));
    check("R6 all on", en_now(), en_word(1, 1, 1));
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin : main
    int v;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 enables", en_now(), en_word(1, 1, 1));
    rd(2'd2, v); check("R1 status", v, status_word(0, 0));
    rd(2'd1, v); check("R1 settle", v, 16);
    rd(2'd3, v); check("R1 mask", v, 15);
    rd(2'd0, v); check("R2 ctrl reset", v, 0);

    // R3/R5 directed idle round trip
    enter_idle();
    irq_req = 4'b0100;
    @(negedge clk);
    irq_req = '0;
    check("R5 wake enables", en_now(), en_word(1, 1, 1));
    rd(2'd0, v); check("R2 ctrl readback go clear", v, 1);

    // R5 ext_wake in idle ignored, masked irq ignored
    wr(2'd3, 8'h01);
    enter_idle();
    ext_wake = 1'b1; irq_req = 4'b1110;
    repeat (3) @(negedge clk);
    ext_wake = 1'b0;
    check("R5 masked stays idle", en_now(), en_word(0, 1, 1));
    irq_req = 4'b0001;
    @(negedge clk);
    irq_req = '0;
    check("R5 enabled wakes", en_now(), en_word(1, 1, 1));

    // R8 collision: irq and ctrl write same idle edge
    enter_idle();
    irq_req = 4'b0001;
    wr(2'd0, 8'h06);
    irq_req = '0;
    check("R8 collision active", en_now(), en_word(1, 1, 1));
    rd(2'd0, v); check("R8 ctrl kept", v, 1);
    repeat (2) @(negedge clk);
    rd(2'd2, v); check("R8 no pd", v, status_word(0, 0));

    // R8 write during transit of idle entry
    wr(2'd0, 8'h05);
    wr(2'd0, 8'h06);
    rd(2'd2, v); check("R8 transit write ignored", v, status_word(1, 0));
    irq_req = 4'b0001;
    @(negedge clk);
    irq_req = '0;
    rd(2'd0, v); check("R8 ctrl after transit", v, 1);

    // R4/R6/R9 directed powerdown with retention
    wr(2'd1, 8'd3);
    wr(2'd3, 8'h0A);
    enter_pd();
    irq_req = 4'b1111;
    wr(2'd0, 8'h05);
    @(negedge clk);
    irq_req = '0;
    check("R6 irq ignored in pd", en_now(), en_word(0, 0, 0));
    wake_pd(3);
    rd(2'd1, v); check("R9 settle kept", v, 3);
    rd(2'd3, v); check("R9 mask kept", v, 10);
    rd(2'd0, v); check("R8 ctrl write in pd dropped", v, 2);

    // R6 zero settle corner
    wr(2'd1, 8'd0);
    enter_pd();
    wake_pd(0);

    // Random mix
    wr(2'd3, 8'h0F);
    for (int it = 0; it < 40; it++) begin
      int op;
      op = int'($urandom % 3);
      if (op == 0) begin
        int m;
        int b;
        m = int'($urandom % 16);
        b = int'($urandom % 4);
        wr(2'd3, 8'(m));
        enter_idle();
        irq_req = 4'(1 << b);
        @(negedge clk);
        irq_req = '0;
        check("R5 random irq", int'(cpu_clk_en), (m >> b) & 1);
        if (!cpu_clk_en) begin
          wr(2'd3, 8'(1 << b));
          check("R9 mask write in idle", int'(cpu_clk_en), 0);
          irq_req = 4'(1 << b);
          @(negedge clk);
          irq_req = '0;
          check("R5 random late wake", en_now(), en_word(1, 1, 1));
        end
      end else if (op == 1) begin
        int s;
        s = int'($urandom % 21);
        wr(2'd1, 8'(s));
        enter_pd();
        repeat (int'($urandom % 3)) @(negedge clk);
        wake_pd(s);
      end else begin
        logic [1:0] t;
        t = ($urandom % 2 == 0) ? 2'd0 : 2'd3;
        wr(2'd0, {5'b0, 1'b1, t});
        rd(2'd2, v); check("R7 no busy", v, status_word(0, 0));
        check("R7 enables", en_now(), en_word(1, 1, 1));
        rd(2'd0, v); check("R7 ctrl stored", v, int'(t));
      end
    end

    done_flag = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule